// File: doc/BRIEF.md
# Matching-Cycle Counter with Saturation Flag

This controller samples two single-bit inputs on every rising clock edge and keeps a running tally of the edges at which the two bits agree. A disagreement does not restart the tally. It only pauses it. The tally is three bits wide and stops at its top value of 7.

If another agreeing edge arrives after the tally has reached 7, a sticky saturation flag is set. The flag stays set until the block is cleared or reset.

Both outputs come straight from flip-flops, so no combinational path runs from the compared inputs to the outputs. Reset and the clear strobe are synchronous. Reset has priority over clear, and clear has priority over counting.

Top module: `match_tally`

## Requirements
- R1: While rst is high at a rising clock edge, tally becomes 0 and sat_flag becomes 0 after that edge.
- R2: When rst and clr are low at a rising edge and bit_a equals bit_b (both 0 or both 1), a tally below 7 increments by one.
- R3: When rst and clr are low at a rising edge and bit_a differs from bit_b, tally and sat_flag keep their values.
- R4: A matching edge while tally is 7 leaves tally at 7.
- R5: The first matching edge while tally is 7 sets sat_flag to 1.
- R6: Once sat_flag is 1, it stays 1 through matching and mismatching edges until clr or rst is applied.
- R7: When clr is high and rst is low at an edge, tally becomes 0 and sat_flag becomes 0, whatever the compared bits are. Counting resumes normally on the following edges.
- R8: rst takes priority over clr, and clr takes priority over counting.
- R9: tally and sat_flag change only at rising clock edges, never in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear strobe, active high |
| bit_a | input | 1 | First compared bit |
| bit_b | input | 1 | Second compared bit |
| tally | output | 3 | Count of matching edges, saturating at 7 |
| sat_flag | output | 1 | Sticky flag: a match arrived while tally was 7 |

## Verification
The bench drives the tally into saturation and then applies further matches. A counter that wrapped would return to 0 there, and a counter that flagged too early would raise sat_flag at the edge that reached 7.

It places mismatches both before and after saturation. A design that restarted on a mismatch would lose its count, and a flag that was not sticky would drop.

It also drives clear together with a matching pair, which a design with the wrong priority would count instead of clear. It changes the inputs mid-period, which would expose any combinational path to the outputs.

// File: rtl/match_tally.sv
module match_tally #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             bit_a,
  input  logic             bit_b,
  output logic [WIDTH-1:0] tally,
  output logic             sat_flag
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic same;
  logic at_top;

  assign same   = (bit_a == bit_b);
  assign at_top = (tally == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      tally    <= '0;
      sat_flag <= 1'b0;
    end else if (clr) begin
      tally    <= '0;
      sat_flag <= 1'b0;
    end else if (same) begin
      if (at_top) sat_flag <= 1'b1;
      else        tally    <= tally + 1'b1;
    end
  end

  // R1
  rst_zero_chk: assert property (@(posedge clk) rst |=> (tally == '0 && !sat_flag));
  // R7
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst) clr |=> (tally == '0 && !sat_flag));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && bit_a != bit_b) |=> ($stable(tally) && $stable(sat_flag)));
  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && bit_a == bit_b && tally != TOP) |=> (tally == $past(tally) + 1'b1));
  // R4
  cap_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && bit_a == bit_b && tally == TOP) |=> (tally == TOP && sat_flag));
  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (sat_flag && !clr) |=> sat_flag);
  // R5
  flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sat_flag) |-> ($past(tally) == TOP));
endmodule

// File: tb/match_tally_test.sv
module match_tally_test;
  logic clk = 1'b0;
  logic rst, clr, bit_a, bit_b;
  logic [2:0] tally;
  logic sat_flag;
  int checks = 0, fails = 0;
  int exp_t;
  bit exp_f;

  always #4 clk = ~clk;

  match_tally uut (.clk(clk), .rst(rst), .clr(clr), .bit_a(bit_a), .bit_b(bit_b),
                   .tally(tally), .sat_flag(sat_flag));

  function automatic int next_t(int t, bit r, bit c, bit a, bit b);
    if (r || c) return 0;
    if (a == b && t < 7) return t + 1;
    return t;
  endfunction

  function automatic bit next_f(int t, bit f, bit r, bit c, bit a, bit b);
    if (r || c) return 1'b0;
    if (a == b && t == 7) return 1'b1;
    return f;
  endfunction

  task automatic check(string req);
    checks++;
    if (tally !== exp_t[2:0] || sat_flag !== exp_f) begin
      fails++;
      $display("FAIL %s: tally=%0d flag=%0b expected tally=%0d flag=%0b",
               req, tally, sat_flag, exp_t, exp_f);
    end
  endtask

  task automatic step(bit r, bit c, bit a, bit b, string req);
    rst = r; clr = c; bit_a = a; bit_b = b;
    @(posedge clk);
    exp_f = next_f(exp_t, exp_f, r, c, a, b);
    exp_t = next_t(exp_t, r, c, a, b);
    #2;
    check(req);
    bit_a = ~a;  // R9: mid-period change must not reach outputs
    #1;
    check("R9");
  endtask

  initial begin
    #150000;
    fails++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    exp_t = 0; exp_f = 0;
    rst = 1; clr = 0; bit_a = 1; bit_b = 1;
    @(posedge clk); #2; check("R1");
    step(1, 1, 0, 0, "R1");
    step(0, 0, 0, 0, "R2");
    step(0, 0, 1, 1, "R2");
    step(0, 0, 1, 0, "R3");
    step(0, 0, 0, 1, "R3");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, "R2");
    step(0, 0, 1, 1, "R5");
    step(0, 0, 1, 1, "R4");
    step(0, 0, 0, 1, "R6");
    step(0, 0, 0, 0, "R6");
    step(0, 1, 1, 1, "R7");
    step(0, 1, 0, 0, "R8");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, "R7");
    step(1, 1, 1, 1, "R8");
    for (int i = 0; i < 9; i++) step(0, 0, 1, 1, "R4");
    step(1, 0, 1, 1, "R1");
    void'($urandom(32'd77));
    for (int i = 0; i < 400; i++) begin
      int rr = $urandom_range(0, 99);
      step(rr < 2, rr >= 2 && rr < 7, 1'($urandom), 1'($urandom), "R6");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule